// File: doc/BRIEF.md
# MSI-X Vector Table with Pending Bits

This block is the interrupt message engine of a PCIe-style endpoint. Software programs one entry per vector through an aligned register port. Each entry holds a 64-bit message address, a 32-bit message data word and a per-vector mask. Logic inside the device raises an interrupt by vector index. The block then either presents that vector's address and data on a valid/ready message output, or records the interrupt in a read-only pending bit array when the vector is masked.

Two bits of the capability's message control word are writable here: the global enable and the function-wide mask. Unmasking is level based. Once a vector with a pending bit is no longer masked by its own bit or by the function mask, and the enable bit is set, its message is sent and its pending bit is cleared. Vectors are scanned lowest index first, and the output register is loaded with one vector per handshake. Packet formation and BAR decoding are handled outside the block.

Top module: `msix_vec_unit`

## Requirements
- R1: After reset every vector mask bit reads 1, the enable and function-mask bits read 0, all pending bits read 0, and msg_valid is 0.
- R2: The control word returns the enable bit at bit 15, the function mask at bit 14, N-1 in bits 10:0, and zero in bits 13:11. A control write updates only bits 15 and 14.
- R3: Table entry i sits at byte offset 16*i. Its 32-bit dwords are address low (+0), address high (+4), message data (+8) and vector control (+12). Only bit 0 of vector control (the mask) is stored; its other bits read 0.
- R4: A 64-bit table access at entry offset 0 covers {address high, address low}, and one at offset 8 covers {vector control, message data}. The following read as 0 and are ignored on write: a misaligned access (a 32-bit access with addr[1:0] nonzero, or a 64-bit access with addr[2:0] nonzero) and an access to an entry index of N or more.
- R5: The pending bit of vector n is bit n mod 64 of PBA word n/64, and word w sits at byte offset 8*w. A 32-bit read at +0 or +4 returns the low or high half. Writes to the PBA are ignored. Read data appears with rd_valid in the cycle after the request.
- R6: A trigger on an unmasked vector while enabled puts that entry's {address, data} on the output. msg_valid rises after the second rising edge that follows the trigger when the output is free.
- R7: A trigger on a vector that is masked per vector or per function sends nothing and sets the vector's pending bit.
- R8: Clearing a vector's mask while the function mask is clear and its pending bit is set sends that vector's message and clears the pending bit.
- R9: When the function mask is cleared, every pending vector whose own mask is clear is sent, one per accepted handshake, in ascending index order, and its pending bit is cleared.
- R10: While the enable bit is 0, triggers are dropped without setting a pending bit, and no message is loaded.
- R11: While msg_valid is 1 and msg_ready is 0, msg_valid, msg_addr and msg_data hold.
- R12: A trigger that lands on the same vector in the same cycle that the vector's pending bit is replayed produces exactly one message and leaves the pending bit clear.
- R13: A trigger with a vector index of N or more has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write value |
| ctl_rdata | output | 16 | Control word read value |
| acc_req | input | 1 | Table/PBA access request |
| acc_we | input | 1 | Access is a write |
| acc_pba | input | 1 | 1 selects the PBA, 0 the table |
| acc_wide | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| acc_addr | input | AW | Byte offset within the selected space |
| acc_wdata | input | 64 | Write data (low 32 bits for narrow) |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data (narrow reads zero-extended) |
| trig_valid | input | 1 | Interrupt request strobe |
| trig_vec | input | 11 | Requested vector index |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that msg_ready is a plain consumer input and that reset is held for at least one edge. They also assume that trigger, control and access inputs change only between clock edges. The bench drives every input on the falling edge and samples shortly after it. A masked-trigger property checks the pending state at the following edge, so it relies on the mask bits settling in the same cycle they are sampled. The bench never issues a table write and a trigger to the same vector in one cycle, except in the single deliberate collision case.

// File: rtl/msix_pkg.sv
package msix_pkg;

    localparam int MAX_VEC    = 2048;
    localparam int VEC_IDX_W  = 11;
    localparam int CTL_EN_BIT = 15;
    localparam int CTL_FM_BIT = 14;

    typedef enum logic [1:0] {
        DW_ADDR_LO = 2'd0,
        DW_ADDR_HI = 2'd1,
        DW_DATA    = 2'd2,
        DW_VCTL    = 2'd3
    } dword_e;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        mask;
    } entry_t;

    localparam entry_t ENTRY_RST = '{addr_lo: 32'h0, addr_hi: 32'h0, data: 32'h0, mask: 1'b1};

    function automatic logic [15:0] ctl_word(input logic en, input logic fm, input logic [10:0] size_m1);
        logic [15:0] w;
        w = '0;
        w[CTL_EN_BIT] = en;
        w[CTL_FM_BIT] = fm;
        w[10:0] = size_m1;
        return w;
    endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table
    import msix_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              wide,
    input  logic [AW-1:0]     addr,
    input  logic [63:0]       wdata,
    output logic [63:0]       rd_val,
    output logic [N-1:0]      vmask,
    input  logic [(N>1 ? $clog2(N) : 1)-1:0] pick_idx,
    output logic [63:0]       pick_addr,
    output logic [31:0]       pick_data
);
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;
    localparam int EW   = AW - 4;

    logic [EW-1:0] eidx;
    dword_e        dw;
    logic          in_range;
    logic          acc_ok;
    entry_t        tab [N];
    entry_t        rsel;

    assign eidx     = addr[AW-1:4];
    assign dw       = dword_e'(addr[3:2]);
    assign in_range = int'(eidx) < N;
    assign acc_ok   = in_range && (wide ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00));

    for (genvar i = 0; i < N; i++) begin : g_ent
        entry_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= ENTRY_RST;
            end else if (wr && acc_ok && eidx == EW'(i)) begin
                if (wide) begin
                    if (dw == DW_ADDR_LO) begin
                        ent_q.addr_lo <= wdata[31:0];
                        ent_q.addr_hi <= wdata[63:32];
                    end else begin
                        ent_q.data <= wdata[31:0];
                        ent_q.mask <= wdata[32];
                    end
                end else begin
                    case (dw)
                        DW_ADDR_LO: ent_q.addr_lo <= wdata[31:0];
                        DW_ADDR_HI: ent_q.addr_hi <= wdata[31:0];
                        DW_DATA:    ent_q.data    <= wdata[31:0];
                        default:    ent_q.mask    <= wdata[0];
                    endcase
                end
            end
        end
        assign tab[i]   = ent_q;
        assign vmask[i] = ent_q.mask;
    end

    assign rsel = tab[eidx[IDXW-1:0]];

    always_comb begin
        rd_val = '0;
        if (acc_ok) begin
            if (wide) begin
                if (dw == DW_ADDR_LO) rd_val = {rsel.addr_hi, rsel.addr_lo};
                else                  rd_val = {31'b0, rsel.mask, rsel.data};
            end else begin
                case (dw)
                    DW_ADDR_LO: rd_val = {32'b0, rsel.addr_lo};
                    DW_ADDR_HI: rd_val = {32'b0, rsel.addr_hi};
                    DW_DATA:    rd_val = {32'b0, rsel.data};
                    default:    rd_val = {63'b0, rsel.mask};
                endcase
            end
        end
    end

    assign pick_addr = {tab[pick_idx].addr_hi, tab[pick_idx].addr_lo};
    assign pick_data = tab[pick_idx].data;

endmodule

// File: rtl/msix_pending.sv
module msix_pending
    import msix_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 trig_valid,
    input  logic [VEC_IDX_W-1:0] trig_vec,
    input  logic                 en,
    input  logic                 fmask,
    input  logic [N-1:0]         vmask,
    input  logic                 take,
    output logic [N-1:0]         pend,
    output logic                 pick_valid,
    output logic [(N>1 ? $clog2(N) : 1)-1:0] pick_idx
);
    localparam int IDXW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] elig;
    logic [N-1:0] pick_hot;
    logic [N-1:0] trig_hot;
    logic [N-1:0] clr_hot;
    logic         trig_ok;
    logic         fire;

    assign elig = pend & ~vmask & {N{en & ~fmask}};

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                pick_valid = 1'b1;
                pick_idx   = IDXW'(i);
            end
        end
    end

    assign fire     = pick_valid & take;
    assign pick_hot = N'(1) << pick_idx;
    assign clr_hot  = fire ? pick_hot : '0;
    assign trig_ok  = trig_valid && en && (int'(trig_vec) < N);
    assign trig_hot = trig_ok ? (N'(1) << trig_vec) : '0;

    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_hot) | (trig_hot & ~clr_hot);
    end

endmodule

// File: rtl/msix_msg_out.sv
module msix_msg_out
    import msix_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [63:0] in_addr,
    input  logic [31:0] in_data,
    input  logic        ready,
    output logic        valid,
    output logic [63:0] out_addr,
    output logic [31:0] out_data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
        end else if (load) begin
            valid    <= 1'b1;
            out_addr <= in_addr;
            out_data <= in_data;
        end else if (ready) begin
            valid <= 1'b0;
        end
    end
endmodule

// File: rtl/msix_vec_unit.sv
module msix_vec_unit
    import msix_pkg::*;
#(
    parameter int N  = 8,
    parameter int AW = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctl_we,
    input  logic [15:0]          ctl_wdata,
    output logic [15:0]          ctl_rdata,
    input  logic                 acc_req,
    input  logic                 acc_we,
    input  logic                 acc_pba,
    input  logic                 acc_wide,
    input  logic [AW-1:0]        acc_addr,
    input  logic [63:0]          acc_wdata,
    output logic                 rd_valid,
    output logic [63:0]          rd_data,
    input  logic                 trig_valid,
    input  logic [VEC_IDX_W-1:0] trig_vec,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [63:0]          msg_addr,
    output logic [31:0]          msg_data
);
    localparam int IDXW  = (N > 1) ? $clog2(N) : 1;
    localparam int PBA_W = (N + 63) / 64;

    logic            en_q;
    logic            fmask_q;
    logic [N-1:0]    vmask_vec;
    logic [N-1:0]    pend_vec;
    logic            pick_valid;
    logic [IDXW-1:0] pick_idx;
    logic [63:0]     pick_addr;
    logic [31:0]     pick_data;
    logic            take;
    logic [63:0]     tbl_val;
    logic [63:0]     pba_val;
    logic [PBA_W*64-1:0] pba_pad;
    logic            ctl_unused;

    assign ctl_unused = ^ctl_wdata[13:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            fmask_q <= 1'b0;
        end else if (ctl_we) begin
            en_q    <= ctl_wdata[CTL_EN_BIT];
            fmask_q <= ctl_wdata[CTL_FM_BIT];
        end
    end

    assign ctl_rdata = ctl_word(en_q, fmask_q, 11'(N - 1));

    msix_table #(.N(N), .AW(AW)) u_table (
        .clk       (clk),
        .rst       (rst),
        .wr        (acc_req & acc_we & ~acc_pba),
        .wide      (acc_wide),
        .addr      (acc_addr),
        .wdata     (acc_wdata),
        .rd_val    (tbl_val),
        .vmask     (vmask_vec),
        .pick_idx  (pick_idx),
        .pick_addr (pick_addr),
        .pick_data (pick_data)
    );

    assign take = ~msg_valid | msg_ready;

    msix_pending #(.N(N)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .trig_valid (trig_valid),
        .trig_vec   (trig_vec),
        .en         (en_q),
        .fmask      (fmask_q),
        .vmask      (vmask_vec),
        .take       (take),
        .pend       (pend_vec),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    msix_msg_out u_out (
        .clk      (clk),
        .rst      (rst),
        .load     (pick_valid & take),
        .in_addr  (pick_addr),
        .in_data  (pick_data),
        .ready    (msg_ready),
        .valid    (msg_valid),
        .out_addr (msg_addr),
        .out_data (msg_data)
    );

    always_comb begin
        pba_pad = '0;
        pba_pad[N-1:0] = pend_vec;
    end

    always_comb begin
        logic [63:0] word;
        logic        ok;
        int          widx;
        widx = int'(acc_addr[AW-1:3]);
        ok   = (widx < PBA_W) && (acc_wide ? (acc_addr[2:0] == 3'b000) : (acc_addr[1:0] == 2'b00));
        word = ok ? pba_pad[widx*64 +: 64] : 64'b0;
        if (!ok)            pba_val = '0;
        else if (acc_wide)  pba_val = word;
        else if (acc_addr[2]) pba_val = {32'b0, word[63:32]};
        else                pba_val = {32'b0, word[31:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_req & ~acc_we;
            if (acc_req && !acc_we) rd_data <= acc_pba ? pba_val : tbl_val;
        end
    end

endmodule

// File: rtl/msix_vec_sva.sv
module msix_vec_sva
    import msix_pkg::*;
#(
    parameter int N = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en,
    input logic                 fmask,
    input logic [N-1:0]         vmask,
    input logic [N-1:0]         pend,
    input logic                 trig_valid,
    input logic [VEC_IDX_W-1:0] trig_vec,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input logic [63:0]          msg_addr,
    input logic [31:0]          msg_data
);
    logic [N-1:0] tsel;
    assign tsel = (trig_valid && int'(trig_vec) < N) ? (N'(1) << trig_vec) : '0;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&vmask) && !en && !fmask && (pend == '0) && !msg_valid);

    a_r7_masked_pends: assert property (@(posedge clk) disable iff (rst)
        (en && (tsel & (vmask | {N{fmask}})) != '0) |=> (pend & $past(tsel)) != '0);

    a_r10_off_pend_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(pend));

    a_r10_off_no_load: assert property (@(posedge clk) disable iff (rst)
        (!en && !msg_valid) |=> !msg_valid);

    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    a_r12_one_new_pend: assert property (@(posedge clk) disable iff (rst)
        $countones(pend) <= $countones($past(pend)) + 1);

endmodule

bind msix_vec_unit msix_vec_sva #(.N(N)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .en         (en_q),
    .fmask      (fmask_q),
    .vmask      (vmask_vec),
    .pend       (pend_vec),
    .trig_valid (trig_valid),
    .trig_vec   (trig_vec),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_addr   (msg_addr),
    .msg_data   (msg_data)
);

// File: tb/sim_msix_vec_unit.sv
module sim_msix_vec_unit;
    localparam int N  = 8;
    localparam int AW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        acc_req = 1'b0, acc_we = 1'b0, acc_pba = 1'b0, acc_wide = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [63:0] acc_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        trig_valid = 1'b0;
    logic [10:0] trig_vec = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [63:0] msg_addr;
    logic [31:0] msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [95:0] exp_q[$];

    always #2 clk = ~clk;

    msix_vec_unit #(.N(N), .AW(AW)) u0 (.*);

    function automatic logic [31:0] lo_of(int i);  return 32'hFEE0_0000 | 32'(i << 4); endfunction
    function automatic logic [31:0] hi_of(int i);  return 32'h0000_0010 + 32'(i);      endfunction
    function automatic logic [31:0] dat_of(int i); return 32'h0000_4100 + 32'(i);      endfunction
    function automatic logic [95:0] msg_of(int i); return {hi_of(i), lo_of(i), dat_of(i)}; endfunction

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_sim();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic ctl_wr(input logic [15:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic acc_write(input bit pba, input bit wide, input int addr, input logic [63:0] v);
        @(negedge clk);
        acc_req = 1'b1; acc_we = 1'b1; acc_pba = pba; acc_wide = wide;
        acc_addr = AW'(addr); acc_wdata = v;
        @(negedge clk);
        acc_req = 1'b0; acc_we = 1'b0;
    endtask

    task automatic acc_read(input bit pba, input bit wide, input int addr, output logic [63:0] v);
        @(negedge clk);
        acc_req = 1'b1; acc_we = 1'b0; acc_pba = pba; acc_wide = wide; acc_addr = AW'(addr);
        @(negedge clk);
        acc_req = 1'b0;
        #1 v = rd_data;
    endtask

    task automatic expect_read(input bit pba, input bit wide, input int addr, input logic [63:0] exp, input string req);
        logic [63:0] v;
        acc_read(pba, wide, addr, v);
        check(v == exp, req, {32'b0, v}, {32'b0, exp});
    endtask

    task automatic trigger(input int v);
        @(negedge clk); trig_valid = 1'b1; trig_vec = 11'(v);
        @(negedge clk); trig_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk); #1;
            if (!rst && msg_valid && msg_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7/R10 unexpected message", {msg_addr, msg_data}, 96'b0);
                end else begin
                    logic [95:0] e;
                    e = exp_q.pop_front();
                    check({msg_addr, msg_data} == e, "R6/R8/R9 message content or order", {msg_addr, msg_data}, e);
                end
            end
        end
    end

    initial begin
        #(4 * 50000);
        check(1'b0, "watchdog", 96'b0, 96'b0);
        finish_sim();
    end

    initial begin
        logic [95:0] held;
        idle(3);
        @(negedge clk); rst = 1'b0;
        #1;
        // R1 / R2 reset state
        check(ctl_rdata == 16'h0007, "R1 R2 control word after reset", {80'b0, ctl_rdata}, 96'h7);
        check(!msg_valid, "R1 msg_valid after reset", {95'b0, msg_valid}, 96'b0);
        expect_read(1'b0, 1'b0, 3*16 + 12, 64'h1, "R1 vector mask set after reset");
        expect_read(1'b1, 1'b1, 0, 64'h0, "R1 pending clear after reset");

        // program table: narrow writes for 0..3, wide for 4..7
        for (int i = 0; i < 4; i++) begin
            acc_write(1'b0, 1'b0, i*16 + 0, {32'b0, lo_of(i)});
            acc_write(1'b0, 1'b0, i*16 + 4, {32'b0, hi_of(i)});
            acc_write(1'b0, 1'b0, i*16 + 8, {32'b0, dat_of(i)});
        end
        for (int i = 4; i < 8; i++) begin
            acc_write(1'b0, 1'b1, i*16 + 0, {hi_of(i), lo_of(i)});
            acc_write(1'b0, 1'b1, i*16 + 8, {32'h1, dat_of(i)});
        end
        expect_read(1'b0, 1'b0, 2*16 + 4, {32'b0, hi_of(2)}, "R3 narrow read address high");
        expect_read(1'b0, 1'b0, 5*16 + 8, {32'b0, dat_of(5)}, "R3 narrow read of wide-written data");
        expect_read(1'b0, 1'b1, 1*16 + 0, {hi_of(1), lo_of(1)}, "R4 wide read at offset 0");
        expect_read(1'b0, 1'b1, 6*16 + 8, {32'h1, dat_of(6)}, "R4 wide read at offset 8");
        expect_read(1'b0, 1'b1, 1*16 + 4, 64'h0, "R4 misaligned wide read is zero");
        expect_read(1'b0, 1'b0, 8*16 + 0, 64'h0, "R4 out-of-range entry reads zero");
        acc_write(1'b0, 1'b1, 0*16 + 4, 64'hDEAD_BEEF_CAFE_F00D);
        expect_read(1'b0, 1'b1, 0, {hi_of(0), lo_of(0)}, "R4 misaligned wide write ignored");
        acc_write(1'b0, 1'b0, 7*16 + 12, 64'hFFFF_FFFF);
        expect_read(1'b0, 1'b0, 7*16 + 12, 64'h1, "R3 vector control upper bits read zero");

        // R10: disabled, unmasked vector 0 triggered -> dropped
        acc_write(1'b0, 1'b0, 0*16 + 12, 64'h0);
        trigger(0);
        idle(3);
        expect_read(1'b1, 1'b1, 0, 64'h0, "R10 trigger while disabled leaves no pending bit");

        // R2 control writes
        ctl_wr(16'hFFFF);
        #1 check(ctl_rdata == 16'hC007, "R2 only enable and mask writable", {80'b0, ctl_rdata}, 96'hC007);
        ctl_wr(16'h8000);
        #1 check(ctl_rdata == 16'h8007, "R2 enable readback", {80'b0, ctl_rdata}, 96'h8007);

        // R6 immediate send with latency
        exp_q.push_back(msg_of(0));
        @(negedge clk); trig_valid = 1'b1; trig_vec = 11'd0;
        @(negedge clk); trig_valid = 1'b0;
        #1 check(!msg_valid, "R6 no message one edge after trigger", {95'b0, msg_valid}, 96'b0);
        @(negedge clk);
        #1 check(msg_valid, "R6 message after second edge", {95'b0, msg_valid}, 96'b1);
        idle(3);

        // R7 masked per vector
        trigger(2);
        trigger(3);
        idle(2);
        expect_read(1'b1, 1'b0, 0, 64'hC, "R7 masked triggers set pending bits");

        // R8 unmask vector 2 replays it
        exp_q.push_back(msg_of(2));
        acc_write(1'b0, 1'b0, 2*16 + 12, 64'h0);
        idle(4);
        expect_read(1'b1, 1'b1, 0, 64'h8, "R8 unmask clears pending bit");

        // R7 function mask, R5 layout and write-ignore
        ctl_wr(16'hC000);
        acc_write(1'b0, 1'b0, 5*16 + 12, 64'h0);
        acc_write(1'b0, 1'b0, 6*16 + 12, 64'h0);
        trigger(6);
        trigger(5);
        trigger(0);
        idle(2);
        expect_read(1'b1, 1'b1, 0, 64'h69, "R7 function mask pends unmasked vectors");
        expect_read(1'b1, 1'b0, 4, 64'h0, "R5 upper half read");
        acc_write(1'b1, 1'b1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_read(1'b1, 1'b0, 0, 64'h69, "R5 PBA write ignored");
        check(exp_q.size() == 0, "R7 nothing sent under function mask", 96'(exp_q.size()), 96'b0);

        // R9 ascending replay with backpressure (R11)
        @(negedge clk); msg_ready = 1'b0;
        exp_q.push_back(msg_of(0));
        exp_q.push_back(msg_of(5));
        exp_q.push_back(msg_of(6));
        ctl_wr(16'h8000);
        @(negedge clk);
        #1 held = {msg_addr, msg_data};
        check(msg_valid && held == msg_of(0), "R9 lowest vector first", held, msg_of(0));
        idle(3);
        #1 check(msg_valid && {msg_addr, msg_data} == held, "R11 held under backpressure", {msg_addr, msg_data}, held);
        @(negedge clk); msg_ready = 1'b1;
        idle(6);
        check(exp_q.size() == 0, "R9 all replays delivered", 96'(exp_q.size()), 96'b0);
        expect_read(1'b1, 1'b1, 0, 64'h8, "R9 replayed pending bits cleared");

        // R12 trigger collides with replay of vector 3
        exp_q.push_back(msg_of(3));
        acc_write(1'b0, 1'b0, 3*16 + 12, 64'h0);
        trig_valid = 1'b1; trig_vec = 11'd3;
        @(negedge clk); trig_valid = 1'b0;
        idle(5);
        check(exp_q.size() == 0, "R12 single message delivered", 96'(exp_q.size()), 96'b0);
        expect_read(1'b1, 1'b1, 0, 64'h0, "R12 pending clear after collision");

        // R13 out-of-range trigger under function mask
        ctl_wr(16'hC000);
        trigger(9);
        trigger(2047);
        idle(2);
        expect_read(1'b1, 1'b1, 0, 64'h0, "R13 out-of-range trigger ignored");
        ctl_wr(16'h8000);
        idle(5);
        check(exp_q.size() == 0, "R13 no message from out-of-range trigger", 96'(exp_q.size()), 96'b0);

        finish_sim();
    end
endmodule